// File: doc/BRIEF.md
# Debug Exception Stop Filter

This block sits beside a CPU's exception logic and decides, for each exception as it is raised, whether the exception is taken by its normal handler or is handed over to an attached debugger. A per-type stop-enable vector selects which exception kinds the debugger wants to intercept. When an intercepted exception occurs, the block does four things:
- it raises a combinational suppress flag in the same cycle, so the normal handler is not entered;
- it records the exception kind in a sticky reason register;
- it drives the CPU stall level high;
- it leaves the reason register and the stall level updated from the next clock edge on.

Every exception event rewrites the stall level. An exception that is not intercepted therefore releases a stall that was set before. The debugger can overwrite the reason register through a write port, typically with zero to acknowledge the recorded causes. A global debug-disable input forces the stall output low without losing the stored stall level. Selecting the exception vector itself is done elsewhere.

The exception kind arrives as a 4-bit code. The reset is asynchronous and active low, and is released inside the block through a two-stage synchronizer.

Top module: `dbg_exc_stop_filter`

## Requirements
- R1: While reset is held, and until the internal reset release completes, suppress_o, stall_o and reason_o are all 0, whatever is driven on the other inputs.
- R2: Exception codes are 0 reset, 1 bus error, 2 data page fault, 3 instruction page fault, 4 tick timer, 5 alignment, 6 illegal instruction, 7 external interrupt, 8 data TLB miss, 9 instruction TLB miss, 10 range, 11 system call, 12 trap. suppress_o is 1 exactly when exc_valid is 1, exc_code is 12 or less and stop_en[exc_code] is 1. It responds in the same cycle.
- R3: An intercepted exception sets reason_o bit exc_code from the next clock edge. Bits already set remain set, so causes accumulate.
- R4: An exception whose stop_en bit is 0 leaves reason_o unchanged.
- R5: On every cycle with exc_valid high, the stored stall level takes the value of suppress_o for that cycle. An intercepted exception raises it, and any other exception clears it.
- R6: In a cycle with exc_valid low and rsn_wr_en low, both reason_o and the stored stall level hold their values.
- R7: Codes 13 to 15 are never suppressed and leave reason_o unchanged. Because they are still exception events, they clear the stall level.
- R8: rsn_wr_en loads rsn_wr_data into reason_o at the next edge. This write wins over a bit set by an intercepted exception in the same cycle, while the stall level is still updated by that exception.
- R9: stall_o is forced to 0 while dbg_disable is 1. The stored level is kept and reappears on stall_o once dbg_disable returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | An exception is raised this cycle |
| exc_code | input | 4 | Kind of the exception (codes per R2) |
| stop_en | input | 13 | Per-kind intercept enable, bit index = code |
| dbg_disable | input | 1 | Masks the stall output low |
| rsn_wr_en | input | 1 | Debugger write to the reason register |
| rsn_wr_data | input | 13 | Value loaded into the reason register |
| suppress_o | output | 1 | Normal handler must not be entered |
| stall_o | output | 1 | CPU stall level |
| reason_o | output | 13 | Sticky record of intercepted kinds |

## Verification
The hardest case to reach is the collision of a debugger write with an intercepted exception in the same cycle. In that cycle the reason register must take the written value while the stall level still follows the exception. The bench drives both inputs in one cycle, after the reason register has been filled with every cause, so that the write's priority and the stall update are visible separately. A second hard case is a stall that is first set and then released by an out-of-range or non-intercepted code while debug-disable hides the output. The stimulus toggles debug-disable around that release so the stored level can be read back at the stall pin.

// File: rtl/dbgstop_pkg.sv
package dbgstop_pkg;
  localparam int NUM_EXC_DEF = 13;

  typedef enum logic [3:0] {
    EXC_RESET   = 4'd0,
    EXC_BUSERR  = 4'd1,
    EXC_DPAGE   = 4'd2,
    EXC_IPAGE   = 4'd3,
    EXC_TICK    = 4'd4,
    EXC_ALIGN   = 4'd5,
    EXC_ILLEGAL = 4'd6,
    EXC_EXTINT  = 4'd7,
    EXC_DTLB    = 4'd8,
    EXC_ITLB    = 4'd9,
    EXC_RANGE   = 4'd10,
    EXC_SYSCALL = 4'd11,
    EXC_TRAP    = 4'd12
  } exc_kind_e;
endpackage

// File: rtl/dbgstop_rst_sync.sv
module dbgstop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_n_sync = shift_q[STAGES-1];
endmodule

// File: rtl/dbgstop_decode.sv
module dbgstop_decode #(
  parameter  int NUM_EXC = dbgstop_pkg::NUM_EXC_DEF,
  localparam int CODE_W  = $clog2(NUM_EXC)
) (
  input  logic               active,
  input  logic               exc_valid,
  input  logic [CODE_W-1:0]  exc_code,
  input  logic [NUM_EXC-1:0] stop_en,
  output logic [NUM_EXC-1:0] hit_vec,
  output logic               suppress
);
  logic [NUM_EXC-1:0] kind_hot;

  for (genvar i = 0; i < NUM_EXC; i++) begin : g_kind
    assign kind_hot[i] = exc_valid && (exc_code == CODE_W'(i));
  end

  assign hit_vec  = active ? (kind_hot & stop_en) : '0;
  assign suppress = |hit_vec;
endmodule

// File: rtl/dbgstop_state.sv
module dbgstop_state #(
  parameter int NUM_EXC = dbgstop_pkg::NUM_EXC_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt,
  input  logic               suppress,
  input  logic [NUM_EXC-1:0] hit_vec,
  input  logic               wr_en,
  input  logic [NUM_EXC-1:0] wr_data,
  output logic [NUM_EXC-1:0] reason_q,
  output logic               stall_q
);
  logic               reason_en;
  logic [NUM_EXC-1:0] reason_d;
  logic               stall_en;
  logic               stall_d;

  always_comb begin
    reason_en = wr_en || (|hit_vec);
    reason_d  = wr_en ? wr_data : (reason_q | hit_vec);
    stall_en  = evt;
    stall_d   = suppress;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reason_q <= '0;
      stall_q  <= 1'b0;
    end else begin
      if (reason_en) reason_q <= reason_d;
      if (stall_en)  stall_q  <= stall_d;
    end
  end
endmodule

// File: rtl/dbg_exc_stop_filter.sv
module dbg_exc_stop_filter #(
  parameter  int NUM_EXC = dbgstop_pkg::NUM_EXC_DEF,
  localparam int CODE_W  = $clog2(NUM_EXC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_valid,
  input  logic [CODE_W-1:0]  exc_code,
  input  logic [NUM_EXC-1:0] stop_en,
  input  logic               dbg_disable,
  input  logic               rsn_wr_en,
  input  logic [NUM_EXC-1:0] rsn_wr_data,
  output logic               suppress_o,
  output logic               stall_o,
  output logic [NUM_EXC-1:0] reason_o
);
  logic               rst_n_sync;
  logic [NUM_EXC-1:0] hit_vec;
  logic               suppress;
  logic               stall_q;

  dbgstop_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  dbgstop_decode #(.NUM_EXC(NUM_EXC)) u_dec (
    .active    (rst_n_sync),
    .exc_valid (exc_valid),
    .exc_code  (exc_code),
    .stop_en   (stop_en),
    .hit_vec   (hit_vec),
    .suppress  (suppress)
  );

  dbgstop_state #(.NUM_EXC(NUM_EXC)) u_state (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .evt      (exc_valid),
    .suppress (suppress),
    .hit_vec  (hit_vec),
    .wr_en    (rsn_wr_en),
    .wr_data  (rsn_wr_data),
    .reason_q (reason_o),
    .stall_q  (stall_q)
  );

  assign suppress_o = suppress;
  assign stall_o    = stall_q && !dbg_disable;
endmodule

// File: rtl/dbg_exc_stop_filter_chk.sv
module dbg_exc_stop_filter_chk #(
  parameter  int NUM_EXC = dbgstop_pkg::NUM_EXC_DEF,
  localparam int CODE_W  = $clog2(NUM_EXC)
) (
  input logic               clk,
  input logic               rst_n_sync,
  input logic               exc_valid,
  input logic [CODE_W-1:0]  exc_code,
  input logic               dbg_disable,
  input logic               rsn_wr_en,
  input logic [NUM_EXC-1:0] rsn_wr_data,
  input logic               suppress_o,
  input logic               stall_o,
  input logic [NUM_EXC-1:0] reason_o
);
  AST_NO_EVENT_NO_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !exc_valid |-> !suppress_o); // R2

  AST_REASON_STICKY: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !rsn_wr_en |=> ((reason_o & $past(reason_o)) == $past(reason_o))); // R3

  AST_HIT_RECORDED: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (exc_valid && suppress_o && !rsn_wr_en) |=>
      (|(reason_o & (NUM_EXC'(1) << $past(exc_code))))); // R3

  AST_MISS_KEEPS_REASON: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (exc_valid && !suppress_o && !rsn_wr_en) |=> (reason_o == $past(reason_o))); // R4

  AST_STALL_FOLLOWS_EVENT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    exc_valid |=> (stall_o == ($past(suppress_o) && !dbg_disable))); // R5

  AST_IDLE_HOLDS_REASON: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!exc_valid && !rsn_wr_en) |=> $stable(reason_o)); // R6

  AST_RANGE_NO_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (exc_valid && (32'(exc_code) >= NUM_EXC)) |-> !suppress_o); // R7

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    rsn_wr_en |=> (reason_o == $past(rsn_wr_data))); // R8

  AST_DISABLE_MASKS_STALL: assert property (@(posedge clk) disable iff (!rst_n_sync)
    dbg_disable |-> !stall_o); // R9
endmodule

bind dbg_exc_stop_filter dbg_exc_stop_filter_chk #(.NUM_EXC(NUM_EXC)) chk_i (
  .clk         (clk),
  .rst_n_sync  (rst_n_sync),
  .exc_valid   (exc_valid),
  .exc_code    (exc_code),
  .dbg_disable (dbg_disable),
  .rsn_wr_en   (rsn_wr_en),
  .rsn_wr_data (rsn_wr_data),
  .suppress_o  (suppress_o),
  .stall_o     (stall_o),
  .reason_o    (reason_o)
);

// File: tb/dbg_exc_stop_filter_tb_top.sv
module dbg_exc_stop_filter_tb_top;
  import dbgstop_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 13;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          exc_valid;
  logic [3:0]    exc_code;
  logic [NE-1:0] stop_en;
  logic          dbg_disable;
  logic          rsn_wr_en;
  logic [NE-1:0] rsn_wr_data;
  logic          suppress_o;
  logic          stall_o;
  logic [NE-1:0] reason_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  bit [NE-1:0] m_reason = '0;
  bit          m_stall  = 0;
  bit          in_reset = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_exc_stop_filter dut_i (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
    .stop_en(stop_en), .dbg_disable(dbg_disable), .rsn_wr_en(rsn_wr_en),
    .rsn_wr_data(rsn_wr_data), .suppress_o(suppress_o), .stall_o(stall_o),
    .reason_o(reason_o)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, compare against the model, then
  // advance the model to the state the next rising edge produces.
  task automatic step(bit v, int code, bit [NE-1:0] mask, bit dis,
                      bit wr, bit [NE-1:0] wd, string tag);
    bit exp_sup;
    @(negedge clk);
    exc_valid = v; exc_code = 4'(code); stop_en = mask;
    dbg_disable = dis; rsn_wr_en = wr; rsn_wr_data = wd;
    #1;
    exp_sup = !in_reset && v && (code < NE) && mask[code % NE];
    check(tag, "suppress", int'(suppress_o), int'(exp_sup));
    check(tag, "stall",    int'(stall_o),    int'(m_stall && !dis));
    check(tag, "reason",   int'(reason_o),   int'(m_reason));
    if (!in_reset) begin
      if (wr)           m_reason = wd;
      else if (exp_sup) m_reason = m_reason | (NE'(1) << code);
      if (v)            m_stall  = exp_sup;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    exc_valid = 0; exc_code = '0; stop_en = '0; dbg_disable = 0;
    rsn_wr_en = 0; rsn_wr_data = '0;
    // R1: inputs that would intercept are ignored while reset holds
    step(1, EXC_TRAP, '1, 0, 0, '0, "R1");
    step(1, EXC_RESET, '1, 0, 1, '1, "R1");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) step(0, 0, '0, 0, 0, '0, "R1");
    in_reset = 0;

    // R4: every kind raised with its own enable cleared
    for (int k = 0; k < NE; k++) step(1, k, ~(NE'(1) << k), 0, 0, '0, "R4");
    step(0, 0, '0, 0, 0, '0, "R4");
    // R2/R3: each kind intercepted with a one-hot enable, causes accumulate
    for (int k = 0; k < NE; k++) step(1, k, NE'(1) << k, 0, 0, '0, "R3");
    step(0, 0, '0, 0, 0, '0, "R3");
    // R2: enable set but no exception
    step(0, EXC_ALIGN, '1, 0, 0, '0, "R2");
    // R6: idle cycles keep state
    repeat (3) step(0, 0, '1, 0, 0, '0, "R6");
    // R8: write wins over a simultaneous intercept; stall still follows
    step(1, EXC_IPAGE, '1, 0, 1, '0, "R8");
    step(0, 0, '0, 0, 0, '0, "R8");
    step(0, 0, '0, 0, 1, 13'h0a5a, "R8");
    step(0, 0, '0, 0, 0, '0, "R8");
    // R5: non-intercepted kind clears the stall
    step(1, EXC_TICK, NE'(1) << EXC_TICK, 0, 0, '0, "R5");
    step(1, EXC_SYSCALL, NE'(1) << EXC_TICK, 0, 0, '0, "R5");
    step(0, 0, '0, 0, 0, '0, "R5");
    // R7: out-of-range codes with everything enabled
    step(1, EXC_DTLB, '1, 0, 0, '0, "R7");
    for (int c = 13; c < 16; c++) step(1, c, '1, 0, 0, '0, "R7");
    step(0, 0, '0, 0, 0, '0, "R7");
    // R9: disable masks the level, which reappears afterwards
    step(1, EXC_EXTINT, '1, 1, 0, '0, "R9");
    step(0, 0, '0, 1, 0, '0, "R9");
    step(0, 0, '0, 0, 0, '0, "R9");
    step(1, 15, '1, 1, 0, '0, "R9");
    step(0, 0, '0, 0, 0, '0, "R9");
    // R3/R8 mix: write a pattern then add a cause on top
    step(0, 0, '0, 0, 1, 13'h0101, "R8");
    step(1, EXC_RANGE, '1, 0, 0, '0, "R3");
    step(0, 0, '0, 0, 0, '0, "R3");
    // R1: asynchronous reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0; in_reset = 1; m_reason = '0; m_stall = 0;
    step(1, EXC_TRAP, '1, 0, 0, '0, "R1");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule